// File: doc/BRIEF.md
# Storage Health Counter Aggregator

This block collects the lifetime health statistics of a storage controller and presents them as a 512-byte log image. The image is read one byte at a time by address. Command events, the outstanding-command level, power levels, the shutdown notice, power-loss and media-error strobes feed a set of saturating counters. The warning and status bytes are formed from condition flags that arrive from elsewhere in the controller.

A power sequencing state machine decides which events are counted. Its states are ST_ACTIVE (powered, no shutdown notice), ST_NOTIFIED (powered, notice held), ST_DRAIN (power loss seen, supply still present) and ST_OFF (supply gone). These are its transitions:
- ST_ACTIVE goes to ST_NOTIFIED when the notice rises.
- ST_NOTIFIED goes back to ST_ACTIVE when the notice is withdrawn.
- Either powered state goes to ST_DRAIN on a loss strobe. Loss takes priority over the notice.
- ST_DRAIN goes to ST_OFF when the supply level drops.
- ST_OFF goes to ST_ACTIVE when the supply returns.

Nonvolatile retention sits outside the block. Software keeps the counters by reading them out through the log port and restores them through a byte-write port that accepts the same layout.

Top module: `hlth_log_top`

## Requirements
- R1: A read command (`cmd_kind_i`=1) adds its 512-byte units to a count held as whole thousands plus a remainder in 0..999. The field at byte 32 reports the thousands rounded up, so that 1 to 1000 units read as 1. The remainder carries across commands.
- R2: A command's unit count is `cmd_blocks_i` shifted left by `blk_sz_sel_i`. The block size is 512 << sel, so a 4096-byte block (sel=3) adds 8 units. A block count of 0 adds nothing.
- R3: A normal write (kind 2) adds units to the data-written field at byte 48 and adds 1 to the host-write-command field at byte 80. A write-uncorrectable (kind 3) and kind 0 change neither field.
- R4: Each read command adds 1 to the host-read-command field at byte 64, whatever its block count.
- R5: The busy field at byte 96 gains one minute for every CYC_PER_MIN clock cycles in which `busy_i` is 1. A partial count is kept while `busy_i` is 0.
- R6: The power-on field at byte 128 gains one hour for every CYC_PER_MIN*MIN_PER_HR cycles with `pwr_on_i`=1 and `low_pwr_i`=0. A partial count is kept otherwise.
- R7: A loss strobe taken in ST_ACTIVE adds 1 to the unsafe-shutdown field at byte 144. This includes a notice arriving in the same cycle as the loss. A loss taken in ST_NOTIFIED does not add to it. Each ST_OFF to ST_ACTIVE transition adds 1 to the power-cycle field at byte 112.
- R8: Byte 0 is the warning byte, built from these bits:
  - bit0 = `spare_pct_i` < 10
  - bit1 = `temp_over_i`
  - bit2 = `reliab_deg_i`
  - bit3 = `read_only_i`
  - bit4 = `backup_fail_i`
  - bits 7:5 = 0
- R9: The fixed bytes of the log are:
  - bytes 1 (low) and 2 (high): `temp_k_i`
  - byte 3: `spare_pct_i`
  - byte 4: 10
  - byte 5: `life_used_i`

  Each counter is a 16-byte little-endian field, zero-extended from CTR_W bits. Every other byte reads 0. `rd_data_o` shows the byte at the `rd_addr_i` sampled on the previous clock edge.
- R10: No counter ever wraps. A counter at all ones stays there.
- R11: `nv_wr_i` writes `nv_wdata_i` into lane `nv_addr_i[3:0]` of the counter field that `nv_addr_i` points into. Bits above CTR_W are dropped. For the two data fields, the write also clears the remainder. The write takes priority over an event in the same cycle. Writes to addresses outside the counter fields have no effect.
- R12: In ST_DRAIN and ST_OFF, commands and media-error strobes are ignored. In the powered states, each `media_err_i` strobe adds 1 to the field at byte 160.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_kind_i | input | 2 | 0 none, 1 read, 2 write, 3 write-uncorrectable |
| cmd_blocks_i | input | BLK_W | Number of logical blocks moved |
| blk_sz_sel_i | input | 2 | Block size is 512 << value |
| busy_i | input | 1 | At least one I/O command outstanding |
| pwr_on_i | input | 1 | Supply present |
| low_pwr_i | input | 1 | Controller in a low-power state |
| shn_i | input | 1 | Shutdown notice held |
| pwr_loss_i | input | 1 | Power-loss strobe |
| media_err_i | input | 1 | Unrecovered media error strobe |
| spare_pct_i | input | 8 | Available spare, percent |
| temp_k_i | input | 16 | Temperature in Kelvin |
| temp_over_i | input | 1 | Temperature comparator tripped |
| reliab_deg_i | input | 1 | Reliability degraded |
| read_only_i | input | 1 | Media in read-only mode |
| backup_fail_i | input | 1 | Volatile backup failed |
| life_used_i | input | 8 | Percentage of life used |
| nv_wr_i | input | 1 | Snapshot byte write strobe |
| nv_addr_i | input | 9 | Snapshot byte address |
| nv_wdata_i | input | 8 | Snapshot byte value |
| rd_addr_i | input | 9 | Log byte address |
| rd_data_o | output | 8 | Log byte, one cycle after address |

## Verification
The bench builds the block with CTR_W=20, CYC_PER_MIN=4 and MIN_PER_HR=3. With these values a minute is four cycles and an hour twelve, so the busy and power-on prescalers and their retained remainders can be checked to the exact cycle. The 20-bit counters bring saturation within a few snapshot writes. They also make lanes above bit 20 the dropped-bit case. A sweep of 48 commands covers every command kind and block-size selection, with block counts that cross many thousand-unit boundaries. A 32-point sweep covers every combination of the warning inputs.

// File: rtl/hlth_pkg.sv
package hlth_pkg;

    typedef enum logic [1:0] {
        CMD_NONE      = 2'd0,
        CMD_READ      = 2'd1,
        CMD_WRITE     = 2'd2,
        CMD_WRITE_UNC = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_ACTIVE   = 2'd0,
        ST_NOTIFIED = 2'd1,
        ST_DRAIN    = 2'd2,
        ST_OFF      = 2'd3
    } pwr_st_e;

    localparam int NUM_CTR     = 9;
    localparam int CTR_BASE    = 32;
    localparam int FIELD_BYTES = 16;
    localparam int CTR_END     = CTR_BASE + NUM_CTR * FIELD_BYTES;
    localparam int UNITS_PER_K = 1000;
    localparam logic [7:0] SPARE_LIMIT = 8'd10;

    // counter slots, in log order (slot i sits at CTR_BASE + 16*i)
    localparam int C_DREAD  = 0;
    localparam int C_DWRITE = 1;
    localparam int C_HRD    = 2;
    localparam int C_HWR    = 3;
    localparam int C_BUSY   = 4;
    localparam int C_PCYC   = 5;
    localparam int C_POH    = 6;
    localparam int C_UNSAFE = 7;
    localparam int C_MEDIA  = 8;

endpackage

// File: rtl/hlth_sat_ctr.sv
module hlth_sat_ctr #(
    parameter int W     = 128,
    parameter int INC_W = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_en_i,
    input  logic [INC_W-1:0] inc_amt_i,
    input  logic             ld_en_i,
    input  logic [3:0]       ld_lane_i,
    input  logic [7:0]       ld_byte_i,
    output logic [W-1:0]     val_o
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W:0]   sum;
    logic [W-1:0] ld_val;

    always_comb begin
        sum    = {1'b0, val_o} + (W+1)'(inc_amt_i);
        ld_val = val_o;
        for (int b = 0; b < W; b++) begin
            if ((b / 8) == int'(ld_lane_i)) begin
                ld_val[b] = ld_byte_i[b % 8];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            val_o <= '0;
        end else if (ld_en_i) begin
            val_o <= ld_val;
        end else if (inc_en_i) begin
            val_o <= sum[W] ? MAXV : sum[W-1:0];
        end
    end

    // R10: an increment never makes the value smaller
    p_no_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_en_i && !ld_en_i) |=> (val_o >= $past(val_o)));

endmodule

// File: rtl/hlth_unit_acc.sv
module hlth_unit_acc #(
    parameter int W     = 128,
    parameter int ADD_W = 19
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             add_en_i,
    input  logic [ADD_W-1:0] add_units_i,
    input  logic             ld_en_i,
    input  logic [3:0]       ld_lane_i,
    input  logic [7:0]       ld_byte_i,
    output logic [W-1:0]     thou_o
);
    import hlth_pkg::*;

    localparam int REM_W = 10;
    localparam int SUM_W = ADD_W + 1;
    localparam int Q_W   = SUM_W - 9;

    logic [REM_W-1:0] rem_q;
    logic [SUM_W-1:0] sum;
    logic [Q_W-1:0]   whole;
    logic [REM_W-1:0] part;
    logic [W-1:0]     floor_k;

    always_comb begin
        sum   = SUM_W'(rem_q) + SUM_W'(add_units_i);
        whole = Q_W'(sum / SUM_W'(UNITS_PER_K));
        part  = REM_W'(sum % SUM_W'(UNITS_PER_K));
    end

    hlth_sat_ctr #(.W(W), .INC_W(Q_W)) u_thou (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_en_i  (add_en_i),
        .inc_amt_i (whole),
        .ld_en_i   (ld_en_i),
        .ld_lane_i (ld_lane_i),
        .ld_byte_i (ld_byte_i),
        .val_o     (floor_k)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_q <= '0;
        end else if (ld_en_i) begin
            rem_q <= '0;
        end else if (add_en_i) begin
            rem_q <= part;
        end
    end

    assign thou_o = (&floor_k) ? floor_k : floor_k + W'(rem_q != '0);

    // R1: the carried remainder stays below one thousand units
    p_rem_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rem_q < REM_W'(UNITS_PER_K));

    // R11: a snapshot load leaves no remainder behind
    p_load_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_en_i |=> (rem_q == '0));

endmodule

// File: rtl/hlth_tick.sv
module hlth_tick #(
    parameter longint LIMIT = 60
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R5/R6: the partial count never reaches the period
    p_cnt_in_period_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/hlth_log_top.sv
module hlth_log_top #(
    parameter int     CTR_W       = 128,
    parameter longint CYC_PER_MIN = 64'd15_000_000_000,
    parameter longint MIN_PER_HR  = 60,
    parameter int     BLK_W       = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmd_valid_i,
    input  logic [1:0]       cmd_kind_i,
    input  logic [BLK_W-1:0] cmd_blocks_i,
    input  logic [1:0]       blk_sz_sel_i,
    input  logic             busy_i,
    input  logic             pwr_on_i,
    input  logic             low_pwr_i,
    input  logic             shn_i,
    input  logic             pwr_loss_i,
    input  logic             media_err_i,
    input  logic [7:0]       spare_pct_i,
    input  logic [15:0]      temp_k_i,
    input  logic             temp_over_i,
    input  logic             reliab_deg_i,
    input  logic             read_only_i,
    input  logic             backup_fail_i,
    input  logic [7:0]       life_used_i,
    input  logic             nv_wr_i,
    input  logic [8:0]       nv_addr_i,
    input  logic [7:0]       nv_wdata_i,
    input  logic [8:0]       rd_addr_i,
    output logic [7:0]       rd_data_o
);
    import hlth_pkg::*;

    localparam int     ADD_W      = BLK_W + 3;
    localparam longint CYC_PER_HR = CYC_PER_MIN * MIN_PER_HR;

    pwr_st_e st_q, st_d;
    logic    ev_ok, unsafe_inc, pcyc_inc;

    logic                 cmd_ok, rd_cmd, wr_cmd;
    logic [ADD_W-1:0]     units;
    logic                 busy_tick, poh_tick;
    logic [NUM_CTR-1:0]   ctr_inc;
    logic [NUM_CTR-1:0]   ctr_ld;
    logic [CTR_W-1:0]     ctr_val [NUM_CTR];
    logic [8:0]           nv_off, rd_off;
    logic                 nv_in, rd_in;
    logic [7:0]           warn, rd_byte;
    logic [127:0]         rd_field;

    // ---------------- power sequencing state machine ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_ACTIVE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ACTIVE: begin
                if (pwr_loss_i)  st_d = ST_DRAIN;
                else if (shn_i)  st_d = ST_NOTIFIED;
            end
            ST_NOTIFIED: begin
                if (pwr_loss_i)  st_d = ST_DRAIN;
                else if (!shn_i) st_d = ST_ACTIVE;
            end
            ST_DRAIN: begin
                if (!pwr_on_i)   st_d = ST_OFF;
            end
            ST_OFF: begin
                if (pwr_on_i)    st_d = ST_ACTIVE;
            end
        endcase
    end

    always_comb begin
        ev_ok      = 1'b0;
        unsafe_inc = 1'b0;
        pcyc_inc   = 1'b0;
        unique case (st_q)
            ST_ACTIVE: begin
                ev_ok      = 1'b1;
                unsafe_inc = pwr_loss_i;
            end
            ST_NOTIFIED: ev_ok    = 1'b1;
            ST_DRAIN:    ev_ok    = 1'b0;
            ST_OFF:      pcyc_inc = pwr_on_i;
        endcase
    end

    // ---------------- event decode ----------------
    always_comb begin
        cmd_ok = cmd_valid_i && ev_ok;
        rd_cmd = cmd_ok && (cmd_kind_e'(cmd_kind_i) == CMD_READ);
        wr_cmd = cmd_ok && (cmd_kind_e'(cmd_kind_i) == CMD_WRITE);
        units  = ADD_W'(cmd_blocks_i) << blk_sz_sel_i;
    end

    hlth_tick #(.LIMIT(CYC_PER_MIN)) u_busy_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (busy_i),
        .tick_o (busy_tick)
    );

    hlth_tick #(.LIMIT(CYC_PER_HR)) u_poh_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (pwr_on_i && !low_pwr_i),
        .tick_o (poh_tick)
    );

    always_comb begin
        ctr_inc           = '0;
        ctr_inc[C_DREAD]  = rd_cmd;
        ctr_inc[C_DWRITE] = wr_cmd;
        ctr_inc[C_HRD]    = rd_cmd;
        ctr_inc[C_HWR]    = wr_cmd;
        ctr_inc[C_BUSY]   = busy_tick;
        ctr_inc[C_PCYC]   = pcyc_inc;
        ctr_inc[C_POH]    = poh_tick;
        ctr_inc[C_UNSAFE] = unsafe_inc;
        ctr_inc[C_MEDIA]  = media_err_i && ev_ok;
    end

    // ---------------- snapshot load decode ----------------
    always_comb begin
        nv_off = nv_addr_i - 9'(CTR_BASE);
        nv_in  = nv_wr_i && (nv_addr_i >= 9'(CTR_BASE)) && (nv_addr_i < 9'(CTR_END));
        for (int i = 0; i < NUM_CTR; i++) begin
            ctr_ld[i] = nv_in && (nv_off[7:4] == 4'(i));
        end
    end

    // ---------------- counter bank ----------------
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        if (g == C_DREAD || g == C_DWRITE) begin : g_units
            hlth_unit_acc #(.W(CTR_W), .ADD_W(ADD_W)) u_acc (
                .clk_i       (clk_i),
                .rst_ni      (rst_ni),
                .add_en_i    (ctr_inc[g]),
                .add_units_i (units),
                .ld_en_i     (ctr_ld[g]),
                .ld_lane_i   (nv_off[3:0]),
                .ld_byte_i   (nv_wdata_i),
                .thou_o      (ctr_val[g])
            );
        end else begin : g_plain
            hlth_sat_ctr #(.W(CTR_W), .INC_W(1)) u_ctr (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .inc_en_i  (ctr_inc[g]),
                .inc_amt_i (1'b1),
                .ld_en_i   (ctr_ld[g]),
                .ld_lane_i (nv_off[3:0]),
                .ld_byte_i (nv_wdata_i),
                .val_o     (ctr_val[g])
            );
        end
    end

    // ---------------- log image read port ----------------
    always_comb begin
        warn = {3'b000, backup_fail_i, read_only_i, reliab_deg_i, temp_over_i,
                (spare_pct_i < SPARE_LIMIT)};
        rd_off   = rd_addr_i - 9'(CTR_BASE);
        rd_in    = (rd_addr_i >= 9'(CTR_BASE)) && (rd_addr_i < 9'(CTR_END));
        rd_field = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_off[7:4] == 4'(i)) rd_field = 128'(ctr_val[i]);
        end
        rd_byte = 8'h00;
        case (rd_addr_i)
            9'd0: rd_byte = warn;
            9'd1: rd_byte = temp_k_i[7:0];
            9'd2: rd_byte = temp_k_i[15:8];
            9'd3: rd_byte = spare_pct_i;
            9'd4: rd_byte = SPARE_LIMIT;
            9'd5: rd_byte = life_used_i;
            default: begin
                if (rd_in) rd_byte = rd_field[8*rd_off[3:0] +: 8];
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_data_o <= 8'h00;
        end else begin
            rd_data_o <= rd_byte;
        end
    end

    // R7: unsafe shutdowns only counted from the active state
    p_unsafe_from_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q != ST_ACTIVE && !nv_wr_i) |=> $stable(ctr_val[C_UNSAFE]));

    // R7: power cycles only counted on leaving the off state
    p_pcyc_from_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q != ST_OFF && !nv_wr_i) |=> $stable(ctr_val[C_PCYC]));

    // R12: no command or media event is counted while unpowered
    p_down_ignores_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ev_ok && !nv_wr_i) |=> ($stable(ctr_val[C_HRD]) && $stable(ctr_val[C_MEDIA])));

    // R5: busy time only advances while a command is outstanding
    p_busy_needs_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_i && !nv_wr_i) |=> $stable(ctr_val[C_BUSY]));

    // R8: the top three warning bits read zero
    p_warn_top_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i == 9'd0) |=> (rd_data_o[7:5] == 3'b000));

    // R9: reserved gap between status bytes and counters reads zero
    p_gap_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i >= 9'd6 && rd_addr_i < 9'(CTR_BASE)) |=> (rd_data_o == 8'h00));

endmodule

// File: tb/tb_hlth_log_top.sv
`timescale 1ns/1ps
module tb_hlth_log_top;

    localparam int     CTR_W = 20;
    localparam longint CPM   = 4;
    localparam longint MPH   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        cmd_valid = 0;
    logic [1:0]  cmd_kind = 0;
    logic [15:0] cmd_blocks = 0;
    logic [1:0]  blk_sel = 0;
    logic        busy = 0, pwr_on = 1, low_pwr = 1, shn = 0, loss = 0, merr = 0;
    logic [7:0]  spare = 8'd100;
    logic [15:0] temp = 16'h0135;
    logic        t_over = 0, rel = 0, ro = 0, bk = 0;
    logic [7:0]  life = 8'd7;
    logic        nv_wr = 0;
    logic [8:0]  nv_addr = 0;
    logic [7:0]  nv_data = 0;
    logic [8:0]  rd_addr = 0;
    logic [7:0]  rd_data;

    hlth_log_top #(.CTR_W(CTR_W), .CYC_PER_MIN(CPM), .MIN_PER_HR(MPH), .BLK_W(16)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind), .cmd_blocks_i(cmd_blocks),
        .blk_sz_sel_i(blk_sel), .busy_i(busy), .pwr_on_i(pwr_on), .low_pwr_i(low_pwr),
        .shn_i(shn), .pwr_loss_i(loss), .media_err_i(merr),
        .spare_pct_i(spare), .temp_k_i(temp), .temp_over_i(t_over), .reliab_deg_i(rel),
        .read_only_i(ro), .backup_fail_i(bk), .life_used_i(life),
        .nv_wr_i(nv_wr), .nv_addr_i(nv_addr), .nv_wdata_i(nv_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    int checks = 0;
    int fails  = 0;
    longint u_rd = 0, u_wr = 0, n_hrd = 0, n_hwr = 0, n_media = 0;
    longint n_unsafe = 0, n_pcyc = 0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_byte(input int addr, output logic [7:0] v);
        rd_addr = 9'(addr);
        @(posedge clk);
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic rd_field(input int base, output logic [127:0] v);
        logic [7:0] b;
        v = '0;
        for (int k = 0; k < 16; k++) begin
            rd_byte(base + k, b);
            v[8*k +: 8] = b;
        end
    endtask

    task automatic chk_field(input string tag, input int base, input longint exp);
        logic [127:0] v;
        rd_field(base, v);
        chk(tag, v, 128'(exp));
    endtask

    task automatic chk_byte(input string tag, input int addr, input logic [7:0] exp);
        logic [7:0] v;
        rd_byte(addr, v);
        chk(tag, 128'(v), 128'(exp));
    endtask

    task automatic do_cmd(input int kind, input int blocks, input int sel);
        cmd_valid = 1; cmd_kind = 2'(kind); cmd_blocks = 16'(blocks); blk_sel = 2'(sel);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic nv_write(input int addr, input int data);
        nv_wr = 1; nv_addr = 9'(addr); nv_data = 8'(data);
        @(negedge clk);
        nv_wr = 0;
    endtask

    task automatic pulse_loss();
        loss = 1;
        @(negedge clk);
        loss = 0;
    endtask

    task automatic supply_cycle();
        pwr_on = 0;
        @(negedge clk);
        pwr_on = 1;
        @(negedge clk);
    endtask

    function automatic longint kceil(input longint u);
        return (u + 999) / 1000;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [127:0] v;
        longint exp_v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R9 reset state and fixed bytes
        chk_byte("R8 reset warn", 0, 8'h00);
        chk_byte("R9 temp lo", 1, 8'h35);
        chk_byte("R9 temp hi", 2, 8'h01);
        chk_byte("R9 spare", 3, 8'd100);
        chk_byte("R9 thresh", 4, 8'd10);
        chk_byte("R9 life", 5, 8'd7);
        chk_byte("R9 reserved 6", 6, 8'h00);
        chk_byte("R9 reserved 31", 31, 8'h00);
        chk_byte("R9 reserved 200", 200, 8'h00);
        chk_byte("R9 reserved 511", 511, 8'h00);
        for (int s = 0; s < 9; s++) chk_field("R9 reset counter", 32 + 16 * s, 0);

        // R8 sweep of warning inputs
        for (int m = 0; m < 32; m++) begin
            t_over = m[0]; rel = m[1]; ro = m[2]; bk = m[3];
            spare  = m[4] ? 8'd9 : 8'd10;
            chk_byte("R8 warn sweep", 0, {3'b000, m[3], m[2], m[1], m[0], m[4]});
        end
        t_over = 0; rel = 0; ro = 0; bk = 0; spare = 8'd100;

        // R1 R2 R3 R4 command sweep
        for (int i = 0; i < 48; i++) begin
            int kind, blocks, sel;
            kind = i % 4; blocks = (i * 53) % 700; sel = (i / 4) % 4;
            do_cmd(kind, blocks, sel);
            if (kind == 1) begin u_rd += longint'(blocks) << sel; n_hrd++; end
            if (kind == 2) begin u_wr += longint'(blocks) << sel; n_hwr++; end
            chk_field("R1 R2 data read", 32, kceil(u_rd));
            chk_field("R3 data written", 48, kceil(u_wr));
            chk_field("R4 host reads", 64, n_hrd);
            chk_field("R3 host writes", 80, n_hwr);
        end

        // R12 media errors while powered
        repeat (3) begin merr = 1; @(negedge clk); merr = 0; n_media++; end
        chk_field("R12 media count", 160, n_media);

        // R7 unsafe loss from active
        pulse_loss(); n_unsafe++;
        chk_field("R7 unsafe active", 144, n_unsafe);
        // R12 events ignored while down
        do_cmd(1, 5, 0);
        merr = 1; @(negedge clk); merr = 0;
        chk_field("R12 reads ignored", 64, n_hrd);
        chk_field("R12 data ignored", 32, kceil(u_rd));
        chk_field("R12 media ignored", 160, n_media);
        supply_cycle(); n_pcyc++;
        chk_field("R7 power cycle", 112, n_pcyc);

        // R7 loss after notice: safe
        shn = 1; @(negedge clk);
        pulse_loss();
        shn = 0;
        supply_cycle(); n_pcyc++;
        chk_field("R7 notified loss safe", 144, n_unsafe);
        chk_field("R7 power cycle 2", 112, n_pcyc);

        // R7 notice in same cycle as loss: unsafe
        shn = 1; pulse_loss(); shn = 0; n_unsafe++;
        supply_cycle(); n_pcyc++;
        chk_field("R7 same cycle notice", 144, n_unsafe);

        // R7 notice withdrawn before loss: unsafe
        shn = 1; @(negedge clk); shn = 0; @(negedge clk);
        pulse_loss(); n_unsafe++;
        supply_cycle(); n_pcyc++;
        chk_field("R7 withdrawn notice", 144, n_unsafe);
        chk_field("R7 power cycle 4", 112, n_pcyc);

        do_cmd(1, 2, 0); n_hrd++; u_rd += 2;
        chk_field("R12 powered again", 64, n_hrd);

        // R5 busy minutes
        busy = 1; repeat (9) @(negedge clk); busy = 0;
        chk_field("R5 busy 9 cycles", 96, 2);
        repeat (10) @(negedge clk);
        chk_field("R5 idle holds", 96, 2);
        busy = 1; repeat (3) @(negedge clk); busy = 0;
        chk_field("R5 partial kept", 96, 3);

        // R6 power-on hours
        low_pwr = 0; repeat (30) @(negedge clk); low_pwr = 1;
        chk_field("R6 hours 30 cycles", 128, 2);
        repeat (20) @(negedge clk);
        chk_field("R6 low power excluded", 128, 2);
        low_pwr = 0; repeat (6) @(negedge clk); low_pwr = 1;
        chk_field("R6 partial kept", 128, 3);

        // R11 snapshot loads
        nv_write(80, 8'h45); nv_write(81, 8'h23); nv_write(82, 8'h01);
        chk_field("R11 load host writes", 80, 64'h12345);
        nv_write(83, 8'hAB);
        chk_field("R11 lane above width", 80, 64'h12345);
        nv_write(3, 8'h55);
        chk_byte("R11 non-counter ignored", 3, 8'd100);
        nv_write(48, 5); nv_write(49, 0); nv_write(50, 0);
        chk_field("R11 load data written", 48, 5);
        do_cmd(2, 1, 0);
        chk_field("R11 remainder cleared", 48, 6);
        // write beats same-cycle read command
        nv_wr = 1; nv_addr = 9'd64; nv_data = 8'h77;
        cmd_valid = 1; cmd_kind = 2'd1; cmd_blocks = 16'd1; blk_sel = 2'd0;
        @(negedge clk);
        nv_wr = 0; cmd_valid = 0;
        exp_v = (n_hrd & ~longint'(8'hFF)) | 64'h77;
        chk_field("R11 write wins", 64, exp_v);

        // R10 saturation
        nv_write(96, 8'hFE); nv_write(97, 8'hFF); nv_write(98, 8'hFF);
        chk_field("R10 busy preload", 96, 64'hFFFFE);
        busy = 1; repeat (4) @(negedge clk); busy = 0;
        chk_field("R10 busy to max", 96, 64'hFFFFF);
        busy = 1; repeat (8) @(negedge clk); busy = 0;
        chk_field("R10 busy holds max", 96, 64'hFFFFF);
        nv_write(32, 8'hFF); nv_write(33, 8'hFF); nv_write(34, 8'hFF);
        do_cmd(1, 1000, 3);
        chk_field("R10 data read holds max", 32, 64'hFFFFF);
        rd_field(32, v);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule